// File: doc/BRIEF.md
# Strobed Command Frame Receiver

This block sits between a host processor and the gate logic of a three-level converter. The host places a 32-bit word on a parallel bus and raises a strobe line, which is asynchronous to the local clock. The receiver passes the strobe through a synchroniser and finds its rising edge. On that edge it takes the bus word as one frame. Each frame carries a run flag. When the converter is stopped, a frame carries the configuration: the communication period and the blanking time. When the converter is running, a frame carries a six-bit switching code, one p/n bit pair per phase.

The payload a frame is allowed to change depends on the state the converter is already in. Configuration is taken only while the converter is stopped. A switching code is taken only while it is already running. A switching code that would connect one phase to both rails is refused and raises the error flag. The error flag also rises when, during running, no accepted frame arrives within twice the programmed period. An accepted switching code is presented downstream as a one-cycle valid pulse and then held. The host cannot be stalled, so the code output has valid but no ready. Downstream logic must take the code in the cycle the pulse is high, or read the held value later.

Top module: `cmd_frame_rx`

## Requirements
- R1: After reset, conv_on_o, period_o, blank_o, sw_code_o, sw_vld_o and tx_err_o are all zero.
- R2: A frame is taken only on a rising edge of host_stb_i, and only if bit 28 of the word (the send flag) is 1. A word with bit 28 at 0 changes no output. Outputs reflect a frame on the third rising clock edge after the strobe rises.
- R3: Bit 29 of every accepted word is the run flag (1 = run, 0 = stop). conv_on_o takes its value on each accepted frame.
- R4: A stop frame accepted while conv_on_o is 0 loads period_o from bits 15:0 and blank_o from bits 23:16.
- R5: Configuration is not changed while running. A stop frame accepted while conv_on_o is 1 clears conv_on_o but leaves period_o and blank_o unchanged.
- R6: A run frame accepted while conv_on_o is 1 with a legal code loads sw_code_o from bits 5:0 and pulses sw_vld_o high for exactly one cycle. Bit 5/4 is the phase C p/n pair, bit 3/2 is phase B and bit 1/0 is phase A.
- R7: A run frame accepted while conv_on_o is 0 sets conv_on_o. Its code bits are ignored: sw_code_o holds and there is no pulse.
- R8: A run frame accepted while running whose code has both bits of any pair set is refused. It sets tx_err_o, leaves sw_code_o unchanged and gives no pulse.
- R9: Every other accepted frame clears tx_err_o.
- R10: While running with period_o nonzero, tx_err_o rises if no frame is accepted within 2*period_o clock cycles. With period_o zero this check is off.
- R11: A strobe held high produces one frame only. Bus changes while the strobe stays high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| host_data_i | input | 32 | Frame word from host |
| host_stb_i | input | 1 | Asynchronous frame strobe |
| conv_on_o | output | 1 | Converter run state |
| period_o | output | 16 | Communication period in clock cycles |
| blank_o | output | 8 | Blanking time |
| sw_code_o | output | 6 | Held switching code |
| sw_vld_o | output | 1 | One-cycle pulse for a new code |
| tx_err_o | output | 1 | Transmission error flag |

## Verification
The bench builds the receiver with the default parameters: a 32-bit word, a 16-bit period, an 8-bit blanking field and a two-stage synchroniser. The period is a run-time value, so the bench can program it small (10 cycles) and drive the timeout within a few tens of cycles. It can also program it zero to show that the check is off. During random traffic, periods of at least 64 cycles keep the timeout quiet. Those random runs mix stop and run frames, words with the send flag cleared, and illegal phase pairs.

// File: rtl/cmd_rx_pkg.sv
package cmd_rx_pkg;
  localparam int WORD_W    = 32;
  localparam int PERIOD_W  = 16;
  localparam int BLANK_W   = 8;
  localparam int PHASES    = 3;
  localparam int CODE_W    = 2 * PHASES;
  localparam int RUN_BIT   = 29;
  localparam int SEND_BIT  = 28;
  localparam int PERIOD_LO = 0;
  localparam int BLANK_LO  = 16;
  localparam int CODE_LO   = 0;

  function automatic logic code_illegal(input logic [CODE_W-1:0] c);
    logic bad;
    bad = 1'b0;
    for (int ph = 0; ph < PHASES; ph++)
      bad = bad | (c[2*ph] & c[2*ph+1]);
    return bad;
  endfunction
endpackage

// File: rtl/cmd_stb_sync.sv
module cmd_stb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_async,
  output logic stb_rise
);
  localparam int LAST = STAGES - 1;
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= stb_async;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], stb_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[LAST];

  assign stb_rise = chain_q[LAST] & ~prev_q;
endmodule

// File: rtl/cmd_link_watchdog.sv
module cmd_link_watchdog #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                running,
  input  logic                restart,
  input  logic [PERIOD_W-1:0] period,
  output logic                expired
);
  localparam int CNT_W = PERIOD_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = {1'b0, period, 1'b0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        cnt_q <= '0;
    else if (restart || !running)      cnt_q <= '0;
    else if (cnt_q != CNT_MAX)         cnt_q <= cnt_q + 1'b1;

  assign expired = running && (period != '0) && (cnt_q >= limit);
endmodule

// File: rtl/cmd_frame_decode.sv
module cmd_frame_decode
  import cmd_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_edge,
  input  logic [WORD_W-1:0]   word,
  input  logic                link_expired,
  output logic                frame_acc,
  output logic                conv_on,
  output logic [PERIOD_W-1:0] period,
  output logic [BLANK_W-1:0]  blank,
  output logic [CODE_W-1:0]   code,
  output logic                code_vld,
  output logic                err
);
  logic              run_flag;
  logic [CODE_W-1:0] new_code;
  logic              bad_code;
  logic              take_cfg;
  logic              take_code;

  assign frame_acc = frame_edge & word[SEND_BIT];
  assign run_flag  = word[RUN_BIT];
  assign new_code  = word[CODE_LO +: CODE_W];
  assign bad_code  = run_flag & conv_on & code_illegal(new_code);
  assign take_cfg  = frame_acc & ~run_flag & ~conv_on;
  assign take_code = frame_acc & run_flag & conv_on & ~bad_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_on  <= 1'b0;
      period   <= '0;
      blank    <= '0;
      code     <= '0;
      code_vld <= 1'b0;
      err      <= 1'b0;
    end else begin
      code_vld <= take_code;
      if (frame_acc) begin
        conv_on <= run_flag;
        err     <= bad_code;
      end else if (link_expired) begin
        err     <= 1'b1;
      end
      if (take_cfg) begin
        period <= word[PERIOD_LO +: PERIOD_W];
        blank  <= word[BLANK_LO +: BLANK_W];
      end
      if (take_code) code <= new_code;
    end
  end
endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx
  import cmd_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WORD_W-1:0]   host_data_i,
  input  logic                host_stb_i,
  output logic                conv_on_o,
  output logic [PERIOD_W-1:0] period_o,
  output logic [BLANK_W-1:0]  blank_o,
  output logic [CODE_W-1:0]   sw_code_o,
  output logic                sw_vld_o,
  output logic                tx_err_o
);
  logic stb_rise;
  logic frame_acc;
  logic expired;

  cmd_stb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb_async (host_stb_i),
    .stb_rise  (stb_rise)
  );

  cmd_frame_decode u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_edge   (stb_rise),
    .word         (host_data_i),
    .link_expired (expired),
    .frame_acc    (frame_acc),
    .conv_on      (conv_on_o),
    .period       (period_o),
    .blank        (blank_o),
    .code         (sw_code_o),
    .code_vld     (sw_vld_o),
    .err          (tx_err_o)
  );

  cmd_link_watchdog #(.PERIOD_W(PERIOD_W)) u_wdg (
    .clk     (clk),
    .rst_n   (rst_n),
    .running (conv_on_o),
    .restart (frame_acc),
    .period  (period_o),
    .expired (expired)
  );
endmodule

// File: rtl/cmd_frame_rx_chk.sv
module cmd_frame_rx_chk
  import cmd_rx_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                conv_on_o,
  input logic [PERIOD_W-1:0] period_o,
  input logic [BLANK_W-1:0]  blank_o,
  input logic [CODE_W-1:0]   sw_code_o,
  input logic                sw_vld_o,
  input logic                tx_err_o
);
  p_vld_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_vld_o |=> !sw_vld_o);

  p_vld_only_running_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_vld_o |-> (conv_on_o && $past(conv_on_o)));

  p_code_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_vld_o |-> !code_illegal(sw_code_o));

  p_code_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_vld_o |-> $stable(sw_code_o));

  p_cfg_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(conv_on_o) |-> ($stable(period_o) && $stable(blank_o)));

  p_no_err_on_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_vld_o |-> !tx_err_o);
endmodule

bind cmd_frame_rx cmd_frame_rx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .conv_on_o (conv_on_o),
  .period_o  (period_o),
  .blank_o   (blank_o),
  .sw_code_o (sw_code_o),
  .sw_vld_o  (sw_vld_o),
  .tx_err_o  (tx_err_o)
);

// File: tb/cmd_frame_rx_tb_top.sv
module cmd_frame_rx_tb_top;
  logic        clk;
  logic        rst_n;
  logic [31:0] host_data_i;
  logic        host_stb_i;
  logic        conv_on_o;
  logic [15:0] period_o;
  logic [7:0]  blank_o;
  logic [5:0]  sw_code_o;
  logic        sw_vld_o;
  logic        tx_err_o;

  int n_chk;
  int n_fail;
  int vld_cnt;
  bit done;

  logic        m_on;
  logic [15:0] m_period;
  logic [7:0]  m_blank;
  logic [5:0]  m_code;
  logic        m_err;

  cmd_frame_rx dut_i (
    .clk(clk), .rst_n(rst_n), .host_data_i(host_data_i), .host_stb_i(host_stb_i),
    .conv_on_o(conv_on_o), .period_o(period_o), .blank_o(blank_o),
    .sw_code_o(sw_code_o), .sw_vld_o(sw_vld_o), .tx_err_o(tx_err_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) if (sw_vld_o) vld_cnt++;

  function automatic logic bad_pair(input logic [5:0] c);
    return (c[5] & c[4]) | (c[3] & c[2]) | (c[1] & c[0]);
  endfunction

  function automatic logic [31:0] mk(input bit send, input bit run,
                                     input logic [7:0] b2, input logic [15:0] lo);
    return {2'b00, run, send, 4'b0000, b2, lo};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] d, output int ev);
    ev = 0;
    if (!d[28]) return;
    if (d[29]) begin
      if (m_on) begin
        if (bad_pair(d[5:0])) m_err = 1'b1;
        else begin m_code = d[5:0]; ev = 1; m_err = 1'b0; end
      end else m_err = 1'b0;
    end else begin
      if (!m_on) begin m_period = d[15:0]; m_blank = d[23:16]; end
      m_err = 1'b0;
    end
    m_on = d[29];
  endtask

  task automatic check_all(input string tag, input int ev);
    chk({tag, " R3 on"},     {31'd0, conv_on_o}, {31'd0, m_on});
    chk({tag, " R4 period"}, {16'd0, period_o},  {16'd0, m_period});
    chk({tag, " R5 blank"},  {24'd0, blank_o},   {24'd0, m_blank});
    chk({tag, " R6 code"},   {26'd0, sw_code_o}, {26'd0, m_code});
    chk({tag, " R6 pulses"}, vld_cnt,            ev);
    chk({tag, " R8 err"},    {31'd0, tx_err_o},  {31'd0, m_err});
  endtask

  task automatic send(input logic [31:0] d, input string tag, input int hold = 4);
    int ev;
    @(negedge clk);
    vld_cnt = 0;
    host_data_i = d;
    host_stb_i  = 1'b1;
    repeat (hold) @(negedge clk);
    host_stb_i = 1'b0;
    repeat (3) @(negedge clk);
    model(d, ev);
    check_all(tag, ev);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; vld_cnt = 0; done = 0;
    rst_n = 1'b0; host_stb_i = 1'b0; host_data_i = '0;
    m_on = 0; m_period = 0; m_blank = 0; m_code = 0; m_err = 0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check_all("R1 reset", 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send(mk(1, 0, 8'h21, 16'd10), "R4 cfg");
    send(mk(0, 0, 8'h55, 16'd99), "R2 no-send");
    send(mk(1, 1, 8'h00, 16'h0024), "R7 start");
    send(mk(1, 1, 8'h00, 16'h0024), "R6 code");
    send(mk(1, 0, 8'h77, 16'd500), "R5 stop");
    send(mk(1, 1, 8'h00, 16'h0009), "R7 start2");
    send(mk(1, 1, 8'h00, 16'h0030), "R8 bad");
    send(mk(1, 1, 8'h00, 16'h0012), "R9 clear");
    send(mk(1, 1, 8'h00, 16'h0003), "R8 bad a");

    // R10 timeout with period 10
    send(mk(1, 1, 8'h00, 16'h0006), "R9 before wdg");
    repeat (10) @(negedge clk);
    chk("R10 no timeout yet", {31'd0, tx_err_o}, 32'd0);
    repeat (15) @(negedge clk);
    chk("R10 timeout", {31'd0, tx_err_o}, 32'd1);
    m_err = 1'b1;
    send(mk(1, 1, 8'h00, 16'h0018), "R9 after wdg");

    // R10 zero period disables check
    send(mk(1, 0, 8'h00, 16'h0000), "R5 stop zero");
    send(mk(1, 0, 8'h03, 16'h0000), "R4 zero period");
    send(mk(1, 1, 8'h00, 16'h0000), "R7 start zero");
    repeat (60) @(negedge clk);
    chk("R10 disabled", {31'd0, tx_err_o}, 32'd0);

    // R11 long strobe, bus changes while high
    @(negedge clk);
    vld_cnt = 0;
    host_data_i = mk(1, 1, 8'h00, 16'h0021);
    host_stb_i  = 1'b1;
    repeat (6) @(negedge clk);
    host_data_i = mk(1, 0, 8'h00, 16'h0006);
    repeat (10) @(negedge clk);
    host_stb_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 code kept", {26'd0, sw_code_o}, 32'h21);
    chk("R11 one pulse", vld_cnt, 1);
    chk("R11 still on",  {31'd0, conv_on_o}, 32'd1);
    m_code = 6'h21;

    // random traffic, periods kept large
    send(mk(1, 0, 8'h00, 16'd0), "R5 stop rnd");
    for (int i = 0; i < 300; i++) begin
      logic [31:0] d;
      d = $urandom;
      d[28] = ($urandom % 8) != 0;
      d[15:0] = 16'(64 + ($urandom % 300));
      if (d[29] && ($urandom % 2)) d[5:0] = 6'(($urandom % 2) ? 6'h20 : 6'h08) | d[5:0];
      send(d, "R2 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule